// File: doc/BRIEF.md
# Camera Control Register Block with Configuration-Table Writer

This block is a 32-bit AXI4-Lite slave that holds the control state of a camera front end. It exposes three word registers: a configuration-word register, a restart register for the configuration sequencer, and a colour-format select. Software loads the camera set-up table one entry at a time. Each word written to the configuration register is a command. It carries its own table index, a camera register address and a value, and it makes the block emit a one-cycle write strobe toward a 256-entry, 16-bit configuration memory.

The restart register drives a level output that asks the serial configuration sequencer to run its table again. The format register drives a 3-bit code that tells the pixel path how to unpack the camera bytes. The memory, the sequencer and the pixel path sit outside this block. The block drives only the memory write port and the two control levels.

The address and data halves of a write are accepted independently and in either order. The write is committed once both halves are present. Reads return the stored register contents. Addresses that are unmapped or not word-aligned read as zero.

Top module: `cam_ctrl_regs`

## Requirements
- R1: After reset every register reads zero, `seq_restart` and `mem_we` are low, `pix_fmt` is 000, and `s_bvalid` and `s_rvalid` are low.
- R2: A write handshake on the address channel and one on the data channel may occur in the same cycle or in either order with any gap between them. Exactly one write response follows each write, and its `s_bresp` is 00 (OKAY).
- R3: A write to offset 0x00 raises `mem_we` for exactly one clock cycle. This is the cycle after the later of the two handshakes, and `s_bvalid` rises on the following clock. During that cycle `mem_idx` equals data bits [23:16] and `mem_wdata` equals data bits [15:0]: camera register address in [15:8], value in [7:0].
- R4: Writing the same word to offset 0x00 several times produces one `mem_we` pulse per write.
- R5: Writes to any address other than 0x00 never raise `mem_we`.
- R6: Offset 0x00 reads back the full last word written to it. Bits [31:24] go to the register but never to the memory.
- R7: Bit 0 of offset 0x04 drives `seq_restart` (1 = restart the sequence). Reads of 0x04 return only that bit, with bits [31:1] zero.
- R8: Bits [2:0] of offset 0x08 drive `pix_fmt`, with codes 000 = RGB444, 001 = RGB555 and 010 = RGB565. Reads of 0x08 return only those bits. `pix_fmt` and `seq_restart` change only on the clock that raises `s_bvalid`.
- R9: Reads of an unmapped offset, or of an address with bits [1:0] not zero, return zero. Writes to such addresses change no register. `s_rresp` is always 00.
- R10: While `s_bvalid` is waiting for `s_bready`, both write ready outputs are low and the response is held. While `s_rvalid` is waiting for `s_rready`, `s_arready` is low and `s_rdata` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rst_n | input | 1 | Synchronous reset, active low |
| s_awaddr | input | ADDR_W | Write address (byte address) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (byte address) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| mem_we | output | 1 | One-cycle write strobe for the configuration memory |
| mem_idx | output | 8 | Memory entry index for the strobe |
| mem_wdata | output | 16 | Entry contents: camera register address and value |
| seq_restart | output | 1 | Restart request level for the configuration sequencer |
| pix_fmt | output | 3 | Colour-format select for the pixel path |

## Verification
The checker tests the following on every cycle:
- the strobe lasts a single cycle and is always followed by a response;
- responses are always OKAY;
- a pending response or read datum stays held and blocks new requests on its channel;
- the control levels move only on a committing clock.

The bench scenarios show what a property cannot:
- the strobe carries the right index and entry for every one of the 256 positions under all three channel orderings;
- repeated identical words each commit;
- non-configuration and unmapped writes leave the memory port and the register contents alone;
- every format code reads back masked to its three bits.

// File: rtl/cam_regs_pkg.sv
package cam_regs_pkg;

    localparam int DATA_W  = 32;
    localparam int IDX_W   = 8;
    localparam int ENTRY_W = 16;
    localparam int FMT_W   = 3;
    localparam int DEC_W   = 16;

    localparam logic [DEC_W-1:0] OFS_CFG = 16'h0000;
    localparam logic [DEC_W-1:0] OFS_RST = 16'h0004;
    localparam logic [DEC_W-1:0] OFS_FMT = 16'h0008;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_RST  = 2'd1,
        SEL_FMT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [FMT_W-1:0] {
        FMT_RGB444 = 3'b000,
        FMT_RGB555 = 3'b001,
        FMT_RGB565 = 3'b010
    } pix_fmt_e;

    typedef struct packed {
        logic [7:0] spare;
        logic [7:0] idx;
        logic [7:0] creg;
        logic [7:0] cval;
    } cfg_word_t;

    typedef struct packed {
        logic [IDX_W-1:0]   idx;
        logic [ENTRY_W-1:0] entry;
    } mem_wr_t;

    function automatic reg_sel_e decode_sel(input logic [DEC_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CFG: s = SEL_CFG;
            OFS_RST: s = SEL_RST;
            OFS_FMT: s = SEL_FMT;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic mem_wr_t to_mem(input cfg_word_t w);
        mem_wr_t m;
        m.idx   = w.idx;
        m.entry = {w.creg, w.cval};
        return m;
    endfunction

endpackage

// File: rtl/cam_wr_chan.sv
module cam_wr_chan
    import cam_regs_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    output logic              commit,
    output reg_sel_e          commit_sel,
    output logic [DATA_W-1:0] commit_data
);

    logic              aw_held;
    logic              w_held;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              bvalid_q;

    assign awready     = !aw_held && !bvalid_q;
    assign wready      = !w_held && !bvalid_q;
    assign commit      = aw_held && w_held;
    assign commit_sel  = decode_sel(DEC_W'(addr_q));
    assign commit_data = data_q;
    assign bvalid      = bvalid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_held  <= 1'b0;
            w_held   <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
            bvalid_q <= 1'b0;
        end else begin
            if (awvalid && awready) begin
                aw_held <= 1'b1;
                addr_q  <= awaddr;
            end
            if (wvalid && wready) begin
                w_held <= 1'b1;
                data_q <= wdata;
            end
            if (commit) begin
                aw_held  <= 1'b0;
                w_held   <= 1'b0;
                bvalid_q <= 1'b1;
            end else if (bvalid_q && bready) begin
                bvalid_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cam_rd_chan.sv
module cam_rd_chan
    import cam_regs_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    input  logic              rready,
    output reg_sel_e          rd_sel,
    input  logic [DATA_W-1:0] rd_word
);

    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;

    assign arready = !rvalid_q;
    assign rd_sel  = decode_sel(DEC_W'(araddr));
    assign rvalid  = rvalid_q;
    assign rdata   = rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (arvalid && arready) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_word;
        end else if (rvalid_q && rready) begin
            rvalid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cam_reg_bank.sv
module cam_reg_bank
    import cam_regs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  reg_sel_e           commit_sel,
    input  logic [DATA_W-1:0]  commit_data,
    input  reg_sel_e           rd_sel,
    output logic [DATA_W-1:0]  rd_word,
    output logic               mem_we,
    output logic [IDX_W-1:0]   mem_idx,
    output logic [ENTRY_W-1:0] mem_wdata,
    output logic               seq_restart,
    output logic [FMT_W-1:0]   pix_fmt
);

    cfg_word_t cfg_q;
    logic      rst_q;
    pix_fmt_e  fmt_q;
    mem_wr_t   mw;

    assign mw          = to_mem(cfg_word_t'(commit_data));
    assign mem_we      = commit && (commit_sel == SEL_CFG);
    assign mem_idx     = mw.idx;
    assign mem_wdata   = mw.entry;
    assign seq_restart = rst_q;
    assign pix_fmt     = fmt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            rst_q <= 1'b0;
            fmt_q <= FMT_RGB444;
        end else if (commit) begin
            case (commit_sel)
                SEL_CFG: cfg_q <= cfg_word_t'(commit_data);
                SEL_RST: rst_q <= commit_data[0];
                SEL_FMT: fmt_q <= pix_fmt_e'(commit_data[FMT_W-1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_CFG: rd_word = cfg_q;
            SEL_RST: rd_word = {{(DATA_W-1){1'b0}}, rst_q};
            SEL_FMT: rd_word = {{(DATA_W-FMT_W){1'b0}}, fmt_q};
            default: rd_word = '0;
        endcase
    end

endmodule

// File: rtl/cam_ctrl_regs.sv
module cam_ctrl_regs
    import cam_regs_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  s_awaddr,
    input  logic               s_awvalid,
    output logic               s_awready,
    input  logic [DATA_W-1:0]  s_wdata,
    input  logic               s_wvalid,
    output logic               s_wready,
    output logic [1:0]         s_bresp,
    output logic               s_bvalid,
    input  logic               s_bready,
    input  logic [ADDR_W-1:0]  s_araddr,
    input  logic               s_arvalid,
    output logic               s_arready,
    output logic [DATA_W-1:0]  s_rdata,
    output logic [1:0]         s_rresp,
    output logic               s_rvalid,
    input  logic               s_rready,
    output logic               mem_we,
    output logic [IDX_W-1:0]   mem_idx,
    output logic [ENTRY_W-1:0] mem_wdata,
    output logic               seq_restart,
    output logic [FMT_W-1:0]   pix_fmt
);

    logic              commit;
    reg_sel_e          commit_sel;
    logic [DATA_W-1:0] commit_data;
    reg_sel_e          rd_sel;
    logic [DATA_W-1:0] rd_word;

    assign s_bresp = 2'b00;
    assign s_rresp = 2'b00;

    cam_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .awaddr      (s_awaddr),
        .awvalid     (s_awvalid),
        .awready     (s_awready),
        .wdata       (s_wdata),
        .wvalid      (s_wvalid),
        .wready      (s_wready),
        .bvalid      (s_bvalid),
        .bready      (s_bready),
        .commit      (commit),
        .commit_sel  (commit_sel),
        .commit_data (commit_data)
    );

    cam_rd_chan #(.ADDR_W(ADDR_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .araddr  (s_araddr),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .rdata   (s_rdata),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .rd_sel  (rd_sel),
        .rd_word (rd_word)
    );

    cam_reg_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_sel  (commit_sel),
        .commit_data (commit_data),
        .rd_sel      (rd_sel),
        .rd_word     (rd_word),
        .mem_we      (mem_we),
        .mem_idx     (mem_idx),
        .mem_wdata   (mem_wdata),
        .seq_restart (seq_restart),
        .pix_fmt     (pix_fmt)
    );

endmodule

// File: rtl/cam_ctrl_regs_chk.sv
module cam_ctrl_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        s_awready,
    input logic        s_wready,
    input logic [1:0]  s_bresp,
    input logic        s_bvalid,
    input logic        s_bready,
    input logic        s_arready,
    input logic [31:0] s_rdata,
    input logic [1:0]  s_rresp,
    input logic        s_rvalid,
    input logic        s_rready,
    input logic        mem_we,
    input logic        seq_restart,
    input logic [2:0]  pix_fmt
);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);                                          // R3

    AST_STROBE_THEN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> s_bvalid);                                         // R3

    AST_BRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> (s_bresp == 2'b00));                             // R2

    AST_RRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> (s_rresp == 2'b00));                             // R9

    AST_BRESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);                        // R10

    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> (!s_awready && !s_wready));                      // R10

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));  // R10

    AST_AR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid |-> !s_arready);                                     // R10

    AST_FMT_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pix_fmt) |-> $rose(s_bvalid));                       // R8

    AST_RESTART_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seq_restart) |-> $rose(s_bvalid));                   // R7

endmodule

bind cam_ctrl_regs cam_ctrl_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_awready   (s_awready),
    .s_wready    (s_wready),
    .s_bresp     (s_bresp),
    .s_bvalid    (s_bvalid),
    .s_bready    (s_bready),
    .s_arready   (s_arready),
    .s_rdata     (s_rdata),
    .s_rresp     (s_rresp),
    .s_rvalid    (s_rvalid),
    .s_rready    (s_rready),
    .mem_we      (mem_we),
    .seq_restart (seq_restart),
    .pix_fmt     (pix_fmt)
);

// File: tb/cam_ctrl_regs_tb.sv
module cam_ctrl_regs_tb;

    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] s_awaddr = '0;
    logic          s_awvalid = 1'b0;
    logic          s_awready;
    logic [31:0]   s_wdata = '0;
    logic          s_wvalid = 1'b0;
    logic          s_wready;
    logic [1:0]    s_bresp;
    logic          s_bvalid;
    logic          s_bready = 1'b1;
    logic [AW-1:0] s_araddr = '0;
    logic          s_arvalid = 1'b0;
    logic          s_arready;
    logic [31:0]   s_rdata;
    logic [1:0]    s_rresp;
    logic          s_rvalid;
    logic          s_rready = 1'b1;
    logic          mem_we;
    logic [7:0]    mem_idx;
    logic [15:0]   mem_wdata;
    logic          seq_restart;
    logic [2:0]    pix_fmt;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int cyc = 0;

    logic [31:0] m_cfg = '0;
    logic        m_rst = 1'b0;
    logic [2:0]  m_fmt = '0;

    always #2.5 clk = ~clk;

    cam_ctrl_regs #(.ADDR_W(AW)) u_dut (.*);

    always @(negedge clk) if (mem_we) pulses++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // mode: 0 both together, 1 address first, 2 data first
    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input int mode, input int bhold);
        bit aw_done = 0;
        bit w_done = 0;
        int p0;
        bit is_cfg;
        is_cfg = (a == 5'h00);
        p0 = pulses;
        @(negedge clk);
        s_awaddr = a;
        s_wdata = d;
        if (bhold > 0) s_bready = 1'b0;
        if (mode != 2) s_awvalid = 1'b1;
        if (mode != 1) s_wvalid = 1'b1;
        for (int g = 0; g < 20; g++) begin
            bit ahs;
            bit whs;
            ahs = s_awvalid && s_awready;
            whs = s_wvalid && s_wready;
            @(posedge clk);
            @(negedge clk);
            if (ahs) begin s_awvalid = 1'b0; aw_done = 1; end
            if (whs) begin s_wvalid = 1'b0; w_done = 1; end
            if (aw_done && w_done) break;
            if (mode == 1 && aw_done) s_wvalid = 1'b1;
            if (mode == 2 && w_done) s_awvalid = 1'b1;
        end
        chk(aw_done && w_done, "R2 both halves accepted", {30'b0, aw_done, w_done}, 32'h3);
        // R3: strobe in the cycle after the later handshake, with fields
        chk(mem_we == is_cfg, "R3/R5 strobe timing", {31'b0, mem_we}, {31'b0, is_cfg});
        if (is_cfg) begin
            chk(mem_idx == d[23:16], "R3 mem_idx", {24'b0, mem_idx}, {24'b0, d[23:16]});
            chk(mem_wdata == d[15:0], "R3 mem_wdata", {16'b0, mem_wdata}, {16'b0, d[15:0]});
        end
        chk(!s_bvalid, "R3 no response before strobe cycle ends", {31'b0, s_bvalid}, 32'h0);
        @(negedge clk);
        chk(s_bvalid && s_bresp == 2'b00, "R2 response OKAY", {29'b0, s_bvalid, s_bresp}, 32'h4);
        chk(!mem_we, "R3 strobe one cycle", {31'b0, mem_we}, 32'h0);
        for (int h = 0; h < bhold; h++) begin
            @(negedge clk);
            chk(s_bvalid && !s_awready && !s_wready, "R10 response held, writes blocked",
                {29'b0, s_bvalid, s_awready, s_wready}, 32'h4);
        end
        s_bready = 1'b1;
        @(negedge clk);
        chk(!s_bvalid, "R2 single response", {31'b0, s_bvalid}, 32'h0);
        chk(pulses - p0 == (is_cfg ? 1 : 0), "R4/R5 pulse count", pulses - p0, is_cfg ? 1 : 0);
        case (a)
            5'h00: m_cfg = d;
            5'h04: m_rst = d[0];
            5'h08: m_fmt = d[2:0];
            default: ;
        endcase
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [31:0] exp, input string req, input int rhold);
        @(negedge clk);
        s_araddr = a;
        s_arvalid = 1'b1;
        if (rhold > 0) s_rready = 1'b0;
        for (int g = 0; g < 20; g++) begin
            bit hs;
            hs = s_arready;
            @(posedge clk);
            @(negedge clk);
            if (hs) break;
        end
        s_arvalid = 1'b0;
        chk(s_rvalid && s_rresp == 2'b00, {req, " rvalid/rresp"}, {29'b0, s_rvalid, s_rresp}, 32'h4);
        chk(s_rdata == exp, req, s_rdata, exp);
        for (int h = 0; h < rhold; h++) begin
            @(negedge clk);
            chk(s_rvalid && !s_arready && s_rdata == exp, "R10 read held", s_rdata, exp);
        end
        s_rready = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_outs(input string req);
        chk(seq_restart == m_rst, {req, " seq_restart"}, {31'b0, seq_restart}, {31'b0, m_rst});
        chk(pix_fmt == m_fmt, {req, " pix_fmt"}, {29'b0, pix_fmt}, {29'b0, m_fmt});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!mem_we && !s_bvalid && !s_rvalid, "R1 idle outputs", {29'b0, mem_we, s_bvalid, s_rvalid}, 32'h0);
        check_outs("R1");
        do_read(5'h00, 32'h0, "R1 cfg reset", 0);
        do_read(5'h04, 32'h0, "R1 restart reset", 0);
        do_read(5'h08, 32'h0, "R1 format reset", 0);

        // R3/R2: sweep every memory position, rotating channel order
        for (int i = 0; i < 256; i++) begin
            logic [31:0] w;
            w = {8'(i ^ 8'hA5), 8'(i), 8'(i * 7 + 3), 8'(i ^ 8'h5A)};
            do_write(5'h00, w, i % 3, 0);
        end
        // R6: readback includes bits 31:24
        do_read(5'h00, m_cfg, "R6 cfg readback", 0);

        // R4: identical words each commit
        for (int k = 0; k < 3; k++) do_write(5'h00, 32'h0012_3456, k, 0);
        do_read(5'h00, 32'h0012_3456, "R4/R6 cfg after repeats", 0);

        // R7: restart bit, upper bits masked
        do_write(5'h04, 32'hFFFF_FFFF, 1, 0);
        check_outs("R7 set");
        do_read(5'h04, 32'h1, "R7 restart readback", 0);
        do_write(5'h04, 32'hFFFF_FFFE, 2, 0);
        check_outs("R7 clear");
        do_read(5'h04, 32'h0, "R7 restart cleared", 0);

        // R8: every format code, garbage in upper bits
        for (int f = 0; f < 8; f++) begin
            do_write(5'h08, {29'h1ABC_DEF0 >> f, 3'(f)}, f % 3, 0);
            check_outs("R8 code");
            do_read(5'h08, 32'(f), "R8 format readback", 0);
        end
        do_write(5'h08, 32'h2, 0, 0);
        check_outs("R8 RGB565");

        // R9/R5: unmapped and misaligned writes change nothing
        do_write(5'h0C, 32'hFFFF_FFFF, 0, 0);
        do_write(5'h1C, 32'hFFFF_FFFF, 1, 0);
        do_write(5'h01, 32'hFFFF_FFFF, 2, 0);
        do_write(5'h05, 32'h0000_0000, 0, 0);
        check_outs("R9 after unmapped writes");
        do_read(5'h00, m_cfg, "R9 cfg untouched", 0);
        do_read(5'h08, {29'b0, m_fmt}, "R9 format untouched", 0);
        do_read(5'h0C, 32'h0, "R9 unmapped read", 0);
        do_read(5'h1C, 32'h0, "R9 unmapped top read", 0);
        do_read(5'h02, 32'h0, "R9 misaligned read", 0);

        // R10: back-pressure on both response channels
        do_write(5'h00, 32'h00FF_AA55, 1, 3);
        do_read(5'h00, 32'h00FF_AA55, "R10 cfg read under hold", 4);
        do_write(5'h04, 32'h1, 2, 2);
        check_outs("R10 restart after held response");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule